// File: doc/BRIEF.md
# Receive Buffer Parity Error Address Trap

This block sits beside a parity-protected receive buffer RAM and watches every read that the RAM serves. When a host read issued by the CPU or by DMA returns a word in which a stored parity bit does not match its data byte, the block records the byte address of the failing location in a 10-bit capture register. It also raises an error flag. Reads from other requesters, such as test or internal accesses, are not checked.

The first captured address is held until software reads the capture register. A normal read returns the held value and then restores the register to the default 0x200, and it clears the flag. While the debug suspend input is high, a read is non-destructive: both the address and the flag stay as they were. The capture register has no reset, so a fault address survives any reset of the surrounding logic. The flag is cleared by reset. The held value is meaningful only while the flag is 1.

Top module: `rx_parity_trap`

## Requirements
- R1: `regRdData` presents the capture register in bits 9..0, and bits 31..10 always read as zero.
- R2: The captured value equals 0x200 + 4 * `chkWordIdx` + failing lane, so it always lies in the window 0x200..0x3FF at byte granularity.
- R3: A checked read raises `errFlag` on the next cycle and loads the failing address. A checked read is one with `chkValid` high and `chkRequester` equal to 2'b01 (CPU) or 2'b10 (DMA), where any lane's stored parity bit differs from the XOR of that lane's 8 data bits (even parity). Requester codes 2'b00 and 2'b11 are never checked.
- R4: While `errFlag` is 1, later parity errors do not change the held address.
- R5: A capture-register read (`regRdEn` high) with `dbgSuspend` low returns the held value in that same cycle. From the next cycle the register holds 0x200.
- R6: A capture-register read with `dbgSuspend` low clears `errFlag` on the next cycle.
- R7: A capture-register read with `dbgSuspend` high returns the held value and leaves both `errFlag` and the held address unchanged.
- R8: Asserting `rstN` low clears `errFlag` but leaves the capture register unchanged.
- R9: When several lanes of one word fail, the address of the lowest failing lane (lane 0 = bits 7..0) is captured.
- R10: Some cycles carry both a parity error and a non-suspended register read. If the flag is 1 in that cycle, the read takes effect (default restored, flag cleared) and the error is dropped. If the flag is 0, the error is captured and the flag set.
- R11: A checked read whose parity is correct in every lane leaves `errFlag` low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Asynchronous active-low reset (flag only) |
| chkValid | input | 1 | A RAM read is being served this cycle |
| chkRequester | input | 2 | Requester: 01 CPU, 10 DMA, 00/11 unchecked |
| chkWordIdx | input | 7 | Word index of the read within the receive window |
| chkData | input | 32 | Data word returned by the RAM |
| chkParity | input | 4 | Stored even-parity bit per byte lane |
| regRdEn | input | 1 | Host read of the capture register |
| dbgSuspend | input | 1 | Debug suspend; makes register reads non-destructive |
| regRdData | output | 32 | Capture register read data |
| errFlag | output | 1 | Parity error flag |

## Verification
Two events can fall in one cycle: the capture of a parity error, and the host read that restores the register. The bench provokes this by driving a corrupted CPU read and `regRdEn` on the same clock edge. It does this once with the flag already set and once with it clear. It judges the outcome from the read data returned in that cycle, from `errFlag` one cycle later, and from a follow-up read that shows whether the default or the new address was kept. A suspended read landing on a frozen register is checked the same way: it must change neither state.

// File: rtl/rpt_pkg.sv
package rpt_pkg;

  typedef enum logic [1:0] {
    REQ_NONE = 2'b00,
    REQ_CPU  = 2'b01,
    REQ_DMA  = 2'b10,
    REQ_TEST = 2'b11
  } reqType_t;

  // Strobes from control to datapath
  typedef struct packed {
    logic loadErr;         // load the failing address
    logic restoreDefault;  // return capture register to its default
  } capStrobe_t;

endpackage

// File: rtl/rpt_lane_check.sv
module rpt_lane_check #(
  parameter int BYTE_W = 8
) (
  input  logic [BYTE_W-1:0] laneByte,
  input  logic              laneParity,
  output logic              laneBad
);
  // Even parity: stored bit must equal XOR of the data bits
  assign laneBad = (^laneByte) != laneParity;
endmodule

// File: rtl/rpt_datapath.sv
module rpt_datapath
  import rpt_pkg::*;
#(
  parameter int          ADDR_W       = 10,
  parameter int          LANES        = 4,
  parameter int          BYTE_W       = 8,
  parameter logic [9:0]  WINDOW_BASE  = 10'h200,
  parameter logic [9:0]  DEFAULT_ADDR = 10'h200,
  localparam int         LANE_W       = $clog2(LANES),
  localparam int         WORD_IDX_W   = ADDR_W - 1 - LANE_W,
  localparam int         DATA_W       = LANES * BYTE_W
) (
  input  logic                  clk,
  input  logic                  rstN,
  input  logic                  chkValid,
  input  logic [1:0]            chkRequester,
  input  logic [WORD_IDX_W-1:0] chkWordIdx,
  input  logic [DATA_W-1:0]     chkData,
  input  logic [LANES-1:0]      chkParity,
  input  capStrobe_t            strobes,
  output logic                  errHit,
  output logic [ADDR_W-1:0]     capAddr
);

  logic [LANES-1:0]  laneBad;
  logic [LANE_W-1:0] firstLane;
  logic              hostReq;
  logic [ADDR_W-1:0] errAddr;
  logic [ADDR_W-1:0] capReg;

  for (genvar g = 0; g < LANES; g++) begin : g_lane
    rpt_lane_check #(.BYTE_W(BYTE_W)) u_lane (
      .laneByte  (chkData[g*BYTE_W +: BYTE_W]),
      .laneParity(chkParity[g]),
      .laneBad   (laneBad[g])
    );
  end

  // Lowest failing lane wins: scan from the top down so lane 0 is last
  always_comb begin
    firstLane = '0;
    for (int i = LANES - 1; i >= 0; i--) begin
      if (laneBad[i]) firstLane = LANE_W'(i);
    end
  end

  always_comb begin
    hostReq = (reqType_t'(chkRequester) == REQ_CPU) ||
              (reqType_t'(chkRequester) == REQ_DMA);
    errHit  = chkValid && hostReq && (|laneBad);
    errAddr = WINDOW_BASE | ADDR_W'({chkWordIdx, firstLane});
  end

  // Capture register deliberately has no reset
  always_ff @(posedge clk) begin
    if (strobes.loadErr)             capReg <= errAddr;
    else if (strobes.restoreDefault) capReg <= DEFAULT_ADDR;
  end

  assign capAddr = capReg;

  p_restore_default_r5: assert property (@(posedge clk) disable iff (!rstN)
    strobes.restoreDefault |=> (capAddr == DEFAULT_ADDR))
    else $error("R5: capture register not restored to default");

  p_load_addr_r2: assert property (@(posedge clk) disable iff (!rstN)
    strobes.loadErr |=> (capAddr == $past(errAddr)))
    else $error("R2: failing address not loaded");

endmodule

// File: rtl/rpt_control.sv
module rpt_control
  import rpt_pkg::*;
(
  input  logic       clk,
  input  logic       rstN,
  input  logic       errHit,
  input  logic       regRdEn,
  input  logic       dbgSuspend,
  output capStrobe_t strobes,
  output logic       errFlag
);

  logic readNow;

  always_comb begin
    readNow                = regRdEn && !dbgSuspend;
    // Capture only while unfrozen; a frozen register drops new errors
    strobes.loadErr        = errHit && !errFlag;
    strobes.restoreDefault = readNow && !strobes.loadErr;
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN)                errFlag <= 1'b0;
    else if (strobes.loadErr) errFlag <= 1'b1;
    else if (readNow)         errFlag <= 1'b0;
  end

  p_flag_set_r3: assert property (@(posedge clk) disable iff (!rstN)
    (errHit && !errFlag) |=> errFlag)
    else $error("R3: flag not raised on parity error");

  p_read_clears_r6: assert property (@(posedge clk) disable iff (!rstN)
    (regRdEn && !dbgSuspend && errFlag) |=> !errFlag)
    else $error("R6: flag not cleared by register read");

  p_suspend_keeps_r7: assert property (@(posedge clk) disable iff (!rstN)
    (regRdEn && dbgSuspend && errFlag) |=> errFlag)
    else $error("R7: suspended read cleared flag");

endmodule

// File: rtl/rx_parity_trap.sv
module rx_parity_trap
  import rpt_pkg::*;
#(
  parameter int          ADDR_W       = 10,
  parameter int          REG_W        = 32,
  parameter int          LANES        = 4,
  parameter int          BYTE_W       = 8,
  parameter logic [9:0]  WINDOW_BASE  = 10'h200,
  parameter logic [9:0]  DEFAULT_ADDR = 10'h200,
  localparam int         LANE_W       = $clog2(LANES),
  localparam int         WORD_IDX_W   = ADDR_W - 1 - LANE_W,
  localparam int         DATA_W       = LANES * BYTE_W
) (
  input  logic                  clk,
  input  logic                  rstN,
  input  logic                  chkValid,
  input  logic [1:0]            chkRequester,
  input  logic [WORD_IDX_W-1:0] chkWordIdx,
  input  logic [DATA_W-1:0]     chkData,
  input  logic [LANES-1:0]      chkParity,
  input  logic                  regRdEn,
  input  logic                  dbgSuspend,
  output logic [REG_W-1:0]      regRdData,
  output logic                  errFlag
);

  capStrobe_t        strobes;
  logic              errHit;
  logic [ADDR_W-1:0] capAddr;

  rpt_datapath #(
    .ADDR_W(ADDR_W), .LANES(LANES), .BYTE_W(BYTE_W),
    .WINDOW_BASE(WINDOW_BASE), .DEFAULT_ADDR(DEFAULT_ADDR)
  ) u_dp (
    .clk(clk), .rstN(rstN), .chkValid(chkValid), .chkRequester(chkRequester),
    .chkWordIdx(chkWordIdx), .chkData(chkData), .chkParity(chkParity),
    .strobes(strobes), .errHit(errHit), .capAddr(capAddr)
  );

  rpt_control u_ctl (
    .clk(clk), .rstN(rstN), .errHit(errHit), .regRdEn(regRdEn),
    .dbgSuspend(dbgSuspend), .strobes(strobes), .errFlag(errFlag)
  );

  assign regRdData = {{(REG_W-ADDR_W){1'b0}}, capAddr};

  p_frozen_hold_r4: assert property (@(posedge clk) disable iff (!rstN)
    (errFlag && !regRdEn) |=> $stable(capAddr))
    else $error("R4: frozen address changed");

  p_suspend_addr_r7: assert property (@(posedge clk) disable iff (!rstN)
    (errFlag && regRdEn && dbgSuspend) |=> $stable(capAddr))
    else $error("R7: suspended read changed address");

  p_capture_in_window_r2: assert property (@(posedge clk) disable iff (!rstN)
    errFlag |-> (capAddr >= WINDOW_BASE))
    else $error("R2: captured address outside window");

  p_collide_r10: assert property (@(posedge clk) disable iff (!rstN)
    (errFlag && errHit && regRdEn && !dbgSuspend) |=>
      (!errFlag && capAddr == DEFAULT_ADDR))
    else $error("R10: frozen collision not resolved in favour of read");

endmodule

// File: tb/sim_rx_parity_trap.sv
module sim_rx_parity_trap;

  logic        clk = 1'b0;
  logic        rstN = 1'b0;
  logic        chkValid = 1'b0;
  logic [1:0]  chkRequester = 2'b00;
  logic [6:0]  chkWordIdx = '0;
  logic [31:0] chkData = '0;
  logic [3:0]  chkParity = '0;
  logic        regRdEn = 1'b0;
  logic        dbgSuspend = 1'b0;
  logic [31:0] regRdData;
  logic        errFlag;

  int vectors = 0;
  int miscompares = 0;

  // Behavioural RAM stub
  logic [31:0] ramData [128];
  logic [3:0]  ramPar  [128];

  always #10 clk = ~clk;  // 50 MHz

  rx_parity_trap u0 (
    .clk(clk), .rstN(rstN), .chkValid(chkValid), .chkRequester(chkRequester),
    .chkWordIdx(chkWordIdx), .chkData(chkData), .chkParity(chkParity),
    .regRdEn(regRdEn), .dbgSuspend(dbgSuspend), .regRdData(regRdData),
    .errFlag(errFlag)
  );

  task automatic check(input bit ok, input string tag,
                       input logic [31:0] act, input logic [31:0] exp);
    vectors++;
    if (!ok) begin
      miscompares++;
      $display("FAIL %s actual=%h expected=%h", tag, act, exp);
    end
  endtask

  function automatic logic [9:0] addrOf(input int idx, input int lane);
    return 10'(32'h200 + idx * 4 + lane);
  endfunction

  task automatic ramWrite(input int idx, input logic [31:0] d);
    ramData[idx] = d;
    for (int l = 0; l < 4; l++) ramPar[idx][l] = ^d[l*8 +: 8];
  endtask

  task automatic ramCorrupt(input int idx, input int lane);
    ramPar[idx][lane] = ~ramPar[idx][lane];
  endtask

  // One RAM read, optionally with a simultaneous register read
  task automatic cycleOp(input bit doRam, input int idx, input logic [1:0] req,
                         input bit doReg, input bit susp,
                         output logic [31:0] rd);
    @(negedge clk);
    chkValid = doRam; chkRequester = req; chkWordIdx = 7'(idx);
    chkData = ramData[idx]; chkParity = ramPar[idx];
    regRdEn = doReg; dbgSuspend = susp;
    #2 rd = regRdData;
    @(negedge clk);
    chkValid = 1'b0; regRdEn = 1'b0; dbgSuspend = 1'b0; chkRequester = 2'b00;
  endtask

  task automatic hostRead(input int idx, input logic [1:0] req);
    logic [31:0] d;
    cycleOp(1'b1, idx, req, 1'b0, 1'b0, d);
  endtask

  task automatic regRead(input bit susp, output logic [31:0] rd);
    cycleOp(1'b0, 0, 2'b00, 1'b1, susp, rd);
  endtask

  task automatic t_reset;
    logic [31:0] v;
    check(errFlag === 1'b0, "R8 flag low after reset", 32'(errFlag), 0);
    regRead(1'b0, v);  // initialise the unreset register
    regRead(1'b0, v);
    check(v === 32'h200, "R5 default after read", v, 32'h200);
    check(v[31:10] === '0, "R1 upper bits zero", v, 32'h200);
  endtask

  task automatic t_clean;
    hostRead(9, 2'b01);
    hostRead(9, 2'b10);
    check(errFlag === 1'b0, "R11 clean reads no flag", 32'(errFlag), 0);
  endtask

  task automatic t_single;
    logic [31:0] v;
    ramCorrupt(5, 2);
    hostRead(5, 2'b01);
    check(errFlag === 1'b1, "R3 flag raised", 32'(errFlag), 1);
    regRead(1'b0, v);
    check(v === 32'(addrOf(5, 2)), "R2 captured address", v, 32'(addrOf(5, 2)));
    check(v[31:10] === '0, "R1 upper bits zero on capture", v, 32'(addrOf(5, 2)));
    check(errFlag === 1'b0, "R6 flag cleared by read", 32'(errFlag), 0);
    regRead(1'b0, v);
    check(v === 32'h200, "R5 default restored", v, 32'h200);
    ramWrite(5, ramData[5]);
  endtask

  task automatic t_lowest;
    logic [31:0] v;
    ramCorrupt(127, 3);
    ramCorrupt(127, 1);
    hostRead(127, 2'b10);
    regRead(1'b0, v);
    check(v === 32'(addrOf(127, 1)), "R9 lowest lane wins", v, 32'(addrOf(127, 1)));
    ramWrite(127, ramData[127]);
  endtask

  task automatic t_requester;
    logic [31:0] v;
    ramCorrupt(20, 0);
    hostRead(20, 2'b00);
    hostRead(20, 2'b11);
    check(errFlag === 1'b0, "R3 unchecked requesters ignored", 32'(errFlag), 0);
    regRead(1'b0, v);
    check(v === 32'h200, "R3 no capture from unchecked requester", v, 32'h200);
    ramWrite(20, ramData[20]);
  endtask

  task automatic t_freeze;
    logic [31:0] v;
    ramCorrupt(3, 0);
    ramCorrupt(10, 1);
    hostRead(3, 2'b01);
    hostRead(10, 2'b10);
    check(errFlag === 1'b1, "R4 flag still set", 32'(errFlag), 1);
    regRead(1'b0, v);
    check(v === 32'(addrOf(3, 0)), "R4 first address held", v, 32'(addrOf(3, 0)));
  endtask

  task automatic t_suspend;
    logic [31:0] v;
    hostRead(10, 2'b01);  // word 10 still corrupt
    regRead(1'b1, v);
    check(v === 32'(addrOf(10, 1)), "R7 suspended read value", v, 32'(addrOf(10, 1)));
    check(errFlag === 1'b1, "R7 suspended read keeps flag", 32'(errFlag), 1);
    regRead(1'b1, v);
    check(v === 32'(addrOf(10, 1)), "R7 suspended read keeps address", v, 32'(addrOf(10, 1)));
    regRead(1'b0, v);
    check(errFlag === 1'b0, "R6 normal read after suspend clears", 32'(errFlag), 0);
  endtask

  task automatic t_reset_keeps;
    logic [31:0] v;
    hostRead(3, 2'b01);  // word 3 lane 0 corrupt
    @(negedge clk); rstN = 1'b0;
    @(negedge clk); rstN = 1'b1;
    check(errFlag === 1'b0, "R8 reset clears flag", 32'(errFlag), 0);
    regRead(1'b0, v);
    check(v === 32'(addrOf(3, 0)), "R8 reset keeps address", v, 32'(addrOf(3, 0)));
  endtask

  task automatic t_collide_frozen;
    logic [31:0] v;
    hostRead(3, 2'b01);
    cycleOp(1'b1, 10, 2'b10, 1'b1, 1'b0, v);
    check(v === 32'(addrOf(3, 0)), "R10 frozen collision read value", v, 32'(addrOf(3, 0)));
    check(errFlag === 1'b0, "R10 frozen collision read wins", 32'(errFlag), 0);
    regRead(1'b0, v);
    check(v === 32'h200, "R10 frozen collision error dropped", v, 32'h200);
  endtask

  task automatic t_collide_free;
    logic [31:0] v;
    cycleOp(1'b1, 10, 2'b01, 1'b1, 1'b0, v);
    check(v === 32'h200, "R10 unfrozen collision read value", v, 32'h200);
    check(errFlag === 1'b1, "R10 unfrozen collision captures", 32'(errFlag), 1);
    regRead(1'b0, v);
    check(v === 32'(addrOf(10, 1)), "R10 unfrozen collision address", v, 32'(addrOf(10, 1)));
  endtask

  initial begin
    for (int i = 0; i < 128; i++) ramWrite(i, 32'h1357_9BDF * (i + 1) ^ 32'(i));
    repeat (3) @(negedge clk);
    rstN = 1'b1;
    t_reset();
    t_clean();
    t_single();
    t_lowest();
    t_requester();
    t_freeze();
    t_suspend();
    t_reset_keeps();
    t_collide_frozen();
    t_collide_free();
    $display("== %0d vectors applied, %0d miscompares ==", vectors, miscompares);
    $finish;
  end

  initial begin
    #(20 * 20000);
    miscompares++;
    $display("FAIL watchdog actual=timeout expected=completion");
    $display("== %0d vectors applied, %0d miscompares ==", vectors, miscompares);
    $finish;
  end

endmodule